// File: doc/BRIEF.md
# Segmented Modular Multiplier

The block computes `op_b * op_a mod modulus` for unsigned operands of `N_W` bits. It breaks the multiplier `op_a` into `SEGS` slices of `N_W/SEGS` bits. It works through the slices starting at the most significant one. Each slice takes a window of `N_W/SEGS + 2` cycles.

Inside a window, two lanes run side by side:

- **Multiply lane.** It builds the partial product of the current slice by shift-and-add, one multiplier bit per cycle. It then spends its last two cycles on two reduction steps.
- **Residue lane.** It shrinks the accumulator carried over from the previous slice. It uses a two-bit scan, one bit position per cycle. At each step, the two leading bits `v` at position `p` are replaced by the constant `v*2^N_W mod modulus`, shifted by `p - N_W`.

At the end of each window the accumulator becomes the partial product plus the reduced accumulator shifted left by one slice. One extra window, with no multiplier bits, reduces the last accumulator. A short fix-up stage then subtracts the modulus until the value is below it.

The caller supplies the three fold constants, computed off-block. The caller starts the block with a one-cycle `start` and waits for `done`.

Top module: `mm_segmul`

## Requirements
- R1: When the modulus has its most significant bit set and the fold constants are correct, `result` equals `(op_b * op_a) mod modulus` for every pair of `N_W`-bit operands.
- R2: The operands and the fold constants are captured in the cycle `start` is accepted. `fold1`, `fold2` and `fold3` must equal `1*2^N_W`, `2*2^N_W` and `3*2^N_W` reduced modulo `modulus`. Changes on these inputs after that cycle do not alter the result.
- R3: The `result` presented with `done` is strictly less than `modulus`.
- R4: `done` is high for exactly one clock cycle per accepted `start`.
- R5: Count the clock edge that accepts `start` as edge 0. `done` is set at edge `T+1` to edge `T+4`, where `T = (SEGS+1)*(N_W/SEGS+2)`. For the defaults this is edges 51 to 54.
- R6: A `start` raised while a computation is in progress is ignored. It produces no second `done` and does not change the result of the running computation.
- R7: `result` keeps its value from one `done` to the next, whatever the inputs do in between.
- R8: After reset, `done` is low and `result` is zero.
- R9: Corner cases give the exact residue:
  - a zero multiplier gives 0;
  - a product that is a multiple of the modulus gives 0;
  - all-ones `op_a` with `op_b = modulus-1` gives the full residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation; accepted only when idle |
| op_b | input | N_W | Multiplicand |
| op_a | input | N_W | Multiplier, split into SEGS slices |
| modulus | input | N_W | Modulus, most significant bit set |
| fold1 | input | N_W | 2^N_W mod modulus |
| fold2 | input | N_W | 2*2^N_W mod modulus |
| fold3 | input | N_W | 3*2^N_W mod modulus |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | N_W | Residue, held until the next done |

## Verification
The assertions assume three things about the inputs:

- the modulus has its top bit set;
- the three fold constants are the matching multiples of `2^N_W` reduced by that modulus;
- neither changes in the cycle `start` is accepted.

Only under these conditions are the accumulator bound on entry to the fix-up stage and the "result below modulus" property guaranteed.

The bench uses only normalized moduli. It computes every fold constant itself from the modulus it applies, with 64-bit arithmetic, and drives the constants together with the operands on the start cycle. It changes them only after that cycle, to test that they are ignored.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } mm_state_e;

endpackage

// File: rtl/mm_fold_step.sv
// One two-bit scan step: the bit pair at [pos+1:pos] is removed and its
// weight is re-added as (v * 2^N_W mod modulus) shifted by pos - N_W.
// The bit at ACC_W (above the register) is taken as zero.
module mm_fold_step #(
    parameter int N_W   = 32,
    parameter int ACC_W = 42,
    parameter int POS_W = 6
) (
    input  logic [ACC_W-1:0] x_in,
    input  logic [POS_W-1:0] pos,
    input  logic [N_W-1:0]   f1,
    input  logic [N_W-1:0]   f2,
    input  logic [N_W-1:0]   f3,
    output logic [ACC_W-1:0] x_out
);
    localparam int EXT_W = ACC_W + 1;

    logic [EXT_W-1:0] xe;
    logic [EXT_W-1:0] low_mask;
    logic [EXT_W-1:0] add_term;
    logic [EXT_W-1:0] sum;
    logic [1:0]       pair;
    logic [N_W-1:0]   kv;
    logic [POS_W-1:0] sh;

    always_comb begin
        xe       = {1'b0, x_in};
        pair     = {xe[pos + POS_W'(1)], xe[pos]};
        unique case (pair)
            2'd1:    kv = f1;
            2'd2:    kv = f2;
            2'd3:    kv = f3;
            default: kv = '0;
        endcase
        sh       = pos - POS_W'(N_W);
        low_mask = (EXT_W'(1) << pos) - EXT_W'(1);
        add_term = EXT_W'(kv) << sh;
        sum      = (xe & low_mask) + add_term;
        x_out    = sum[ACC_W-1:0];
    end
endmodule

// File: rtl/mm_mul_lane.sv
// Multiply lane: SEG_W shift-and-add steps, then two reduction steps.
module mm_mul_lane #(
    parameter int N_W   = 32,
    parameter int SEG_W = 8,
    parameter int ACC_W = 42,
    parameter int CNT_W = 4,
    parameter int POS_W = 6
) (
    input  logic [ACC_W-1:0] m_cur,
    input  logic [N_W-1:0]   b_val,
    input  logic             a_bit,
    input  logic [CNT_W-1:0] step,
    input  logic [N_W-1:0]   f1,
    input  logic [N_W-1:0]   f2,
    input  logic [N_W-1:0]   f3,
    output logic [ACC_W-1:0] m_nxt
);
    // step SEG_W -> pos N_W+SEG_W-2, step SEG_W+1 -> pos N_W+SEG_W-3
    localparam int POS_BASE = N_W + 2 * SEG_W - 2;

    logic [POS_W-1:0] fold_pos;
    logic [ACC_W-1:0] folded;
    logic [ACC_W-1:0] shifted_add;

    assign fold_pos = POS_W'(POS_BASE) - POS_W'(step);

    mm_fold_step #(.N_W(N_W), .ACC_W(ACC_W), .POS_W(POS_W)) u_fold (
        .x_in (m_cur),
        .pos  (fold_pos),
        .f1   (f1),
        .f2   (f2),
        .f3   (f3),
        .x_out(folded)
    );

    always_comb begin
        shifted_add = (m_cur << 1) + (a_bit ? ACC_W'(b_val) : '0);
        m_nxt       = (step < CNT_W'(SEG_W)) ? shifted_add : folded;
    end
endmodule

// File: rtl/mm_res_lane.sv
// Residue lane: SEG_W+2 scan steps from pos N_W+SEG_W+1 down to N_W.
module mm_res_lane #(
    parameter int N_W   = 32,
    parameter int SEG_W = 8,
    parameter int ACC_W = 42,
    parameter int CNT_W = 4,
    parameter int POS_W = 6
) (
    input  logic [ACC_W-1:0] r_cur,
    input  logic [CNT_W-1:0] step,
    input  logic [N_W-1:0]   f1,
    input  logic [N_W-1:0]   f2,
    input  logic [N_W-1:0]   f3,
    output logic [ACC_W-1:0] r_nxt
);
    localparam int POS_TOP = N_W + SEG_W + 1;

    logic [POS_W-1:0] fold_pos;

    assign fold_pos = POS_W'(POS_TOP) - POS_W'(step);

    mm_fold_step #(.N_W(N_W), .ACC_W(ACC_W), .POS_W(POS_W)) u_fold (
        .x_in (r_cur),
        .pos  (fold_pos),
        .f1   (f1),
        .f2   (f2),
        .f3   (f3),
        .x_out(r_nxt)
    );
endmodule

// File: rtl/mm_segmul.sv
module mm_segmul
    import mm_pkg::*;
#(
    parameter int N_W  = 32,
    parameter int SEGS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] op_b,
    input  logic [N_W-1:0] op_a,
    input  logic [N_W-1:0] modulus,
    input  logic [N_W-1:0] fold1,
    input  logic [N_W-1:0] fold2,
    input  logic [N_W-1:0] fold3,
    output logic           done,
    output logic [N_W-1:0] result
);
    localparam int SEG_W = N_W / SEGS;
    localparam int ACC_W = N_W + SEG_W + 2;
    localparam int STEPS = SEG_W + 2;
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam int PH_W  = $clog2(SEGS + 1) + 1;
    localparam int POS_W = $clog2(ACC_W + 2);

    typedef struct packed {
        mm_state_e        st;
        logic [PH_W-1:0]  phase;
        logic [CNT_W-1:0] step;
        logic [N_W-1:0]   b;
        logic [N_W-1:0]   a;
        logic [N_W-1:0]   n;
        logic [N_W-1:0]   f1;
        logic [N_W-1:0]   f2;
        logic [N_W-1:0]   f3;
        logic [ACC_W-1:0] m;
        logic [ACC_W-1:0] r;
        logic             done;
        logic [N_W-1:0]   res;
    } mm_regs_t;

    mm_regs_t cur_q, nxt_d;

    logic             mul_active;
    logic             a_bit;
    logic [ACC_W-1:0] m_step;
    logic [ACC_W-1:0] r_step;

    // Multiplier bits enter only during real slices and shift-and-add steps.
    assign mul_active = (cur_q.phase < PH_W'(SEGS)) && (cur_q.step < CNT_W'(SEG_W));
    assign a_bit      = mul_active & cur_q.a[N_W-1];

    mm_mul_lane #(
        .N_W(N_W), .SEG_W(SEG_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .POS_W(POS_W)
    ) u_mul (
        .m_cur(cur_q.m),
        .b_val(cur_q.b),
        .a_bit(a_bit),
        .step (cur_q.step),
        .f1   (cur_q.f1),
        .f2   (cur_q.f2),
        .f3   (cur_q.f3),
        .m_nxt(m_step)
    );

    mm_res_lane #(
        .N_W(N_W), .SEG_W(SEG_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .POS_W(POS_W)
    ) u_res (
        .r_cur(cur_q.r),
        .step (cur_q.step),
        .f1   (cur_q.f1),
        .f2   (cur_q.f2),
        .f3   (cur_q.f3),
        .r_nxt(r_step)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.st    = ST_RUN;
                    nxt_d.phase = '0;
                    nxt_d.step  = '0;
                    nxt_d.b     = op_b;
                    nxt_d.a     = op_a;
                    nxt_d.n     = modulus;
                    nxt_d.f1    = fold1;
                    nxt_d.f2    = fold2;
                    nxt_d.f3    = fold3;
                    nxt_d.m     = '0;
                    nxt_d.r     = '0;
                end
            end
            ST_RUN: begin
                if (mul_active) begin
                    nxt_d.a = cur_q.a << 1;
                end
                if (cur_q.step == CNT_W'(STEPS - 1)) begin
                    nxt_d.step = '0;
                    nxt_d.m    = '0;
                    if (cur_q.phase == PH_W'(SEGS)) begin
                        nxt_d.r  = r_step;
                        nxt_d.st = ST_FIX;
                    end else begin
                        nxt_d.r     = m_step + (r_step << SEG_W);
                        nxt_d.phase = cur_q.phase + PH_W'(1);
                    end
                end else begin
                    nxt_d.step = cur_q.step + CNT_W'(1);
                    nxt_d.m    = m_step;
                    nxt_d.r    = r_step;
                end
            end
            ST_FIX: begin
                if (cur_q.r >= ACC_W'(cur_q.n)) begin
                    nxt_d.r = cur_q.r - ACC_W'(cur_q.n);
                end else begin
                    nxt_d.res  = cur_q.r[N_W-1:0];
                    nxt_d.done = 1'b1;
                    nxt_d.st   = ST_IDLE;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign done   = cur_q.done;
    assign result = cur_q.res;

    // R4: done never lasts two cycles
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.done |=> !cur_q.done);

    // R3: the presented residue is below the captured modulus
    p_result_below_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.done |-> (cur_q.res < cur_q.n));

    // R1: the scan leaves at most N_W+1 significant bits for the fix-up stage
    p_fix_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_FIX) |-> ((cur_q.r >> (N_W + 1)) == '0));

    // R5: every slice window starts with a cleared multiply accumulator
    p_window_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_RUN && cur_q.step == '0) |-> (cur_q.m == '0));

    // R6: captured operands stay frozen while a computation runs
    p_ops_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st != ST_IDLE) |=> ($stable(cur_q.b) && $stable(cur_q.n) && $stable(cur_q.f3)));

    // R7: result only moves together with done
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q.res) |-> cur_q.done);
endmodule

// File: tb/mm_segmul_test.sv
module mm_segmul_test;
    localparam int NW   = 32;
    localparam int SEGS = 4;
    localparam int SW   = NW / SEGS;
    localparam int T    = (SEGS + 1) * (SW + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW-1:0] op_b = '0, op_a = '0, modulus = '0;
    logic [NW-1:0] fold1 = '0, fold2 = '0, fold3 = '0;
    logic          done;
    logic [NW-1:0] result;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    mm_segmul #(.N_W(NW), .SEGS(SEGS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_b(op_b), .op_a(op_a), .modulus(modulus),
        .fold1(fold1), .fold2(fold2), .fold3(fold3),
        .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input longint unsigned act,
                         input longint unsigned exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint unsigned ref_mod(input longint unsigned b, input longint unsigned a,
                                                input longint unsigned n);
        return (b * a) % n;
    endfunction

    task automatic drive_ops(input logic [NW-1:0] b, input logic [NW-1:0] a,
                             input logic [NW-1:0] n);
        longint unsigned nn = 64'(n);
        op_b    = b;
        op_a    = a;
        modulus = n;
        fold1   = NW'((64'd1 << NW) % nn);
        fold2   = NW'((64'd2 << NW) % nn);
        fold3   = NW'((64'd3 << NW) % nn);
    endtask

    // Returns cycles from the accepting edge to done; 0 on timeout.
    task automatic launch_and_wait(output int lat);
        lat = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= T + 40; c++) begin
            @(negedge clk);
            if (done) begin
                lat = c;
                break;
            end
        end
    endtask

    task automatic run_case(input logic [NW-1:0] b, input logic [NW-1:0] a,
                            input logic [NW-1:0] n, input string req);
        int lat;
        longint unsigned exp = ref_mod(64'(b), 64'(a), 64'(n));
        drive_ops(b, a, n);
        launch_and_wait(lat);
        check(lat != 0, {req, " done seen"}, 64'(lat), 64'(T + 1));
        check(64'(result) == exp, {req, " residue"}, 64'(result), exp);
        check(result < n, "R3 result below modulus", 64'(result), 64'(n));
        check(lat >= T + 1 && lat <= T + 4, "R5 latency window", 64'(lat), 64'(T + 1));
        @(negedge clk);
        check(!done, "R4 done single cycle", 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        check(done == 1'b0, "R8 done low after reset", 64'(done), 64'd0);
        check(result == '0, "R8 result zero after reset", 64'(result), 64'd0);
    endtask

    task automatic t_basic;
        run_case(32'h1234_5678, 32'h9abc_def0, 32'hf123_4567, "R1 mixed");
        run_case(32'h0000_0003, 32'h0000_0007, 32'h8000_0001, "R1 small");
        run_case(32'hffff_ffff, 32'h8000_0000, 32'hc000_0005, "R1 b above modulus");
        run_case(32'h5555_5555, 32'haaaa_aaaa, 32'h9e37_79b9, "R2 constants");
    endtask

    task automatic t_corner;
        run_case(32'h7777_1111, 32'h0000_0000, 32'hd000_0003, "R9 zero multiplier");
        run_case(32'h0000_0005, 32'h8000_0001, 32'h8000_0001, "R9 multiple of modulus");
        run_case(32'hffff_fffa, 32'hffff_ffff, 32'hffff_fffb, "R9 max operands");
    endtask

    task automatic t_busy_start;
        int lat;
        int extra = 0;
        longint unsigned exp = ref_mod(64'h0bad_cafe, 64'h1357_9bdf, 64'hfedc_ba97);
        drive_ops(32'h0bad_cafe, 32'h1357_9bdf, 32'hfedc_ba97);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 10; c++) @(negedge clk);
        drive_ops(32'h1111_2222, 32'h3333_4444, 32'h8765_4321);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        for (int c = 12; c <= T + 40; c++) begin
            @(negedge clk);
            if (done) begin
                lat = c;
                break;
            end
        end
        check(lat >= T + 1 && lat <= T + 4, "R6 single run timing", 64'(lat), 64'(T + 1));
        check(64'(result) == exp, "R6 R2 late inputs ignored", 64'(result), exp);
        for (int c = 0; c < T + 20; c++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check(extra == 0, "R6 no second done", 64'(extra), 64'd0);
    endtask

    task automatic t_hold;
        logic [NW-1:0] kept;
        int moved = 0;
        kept = result;
        for (int c = 0; c < 30; c++) begin
            drive_ops(NW'(c * 32'h0101_0107), NW'(c + 5), 32'hc0de_0001);
            @(negedge clk);
            if (result != kept || done) moved++;
        end
        check(moved == 0, "R7 result held without start", 64'(moved), 64'd0);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_corner();
        t_busy_start();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule